// File: doc/BRIEF.md
# Internal Clock Source Selector

This block drives six internal peripheral clock outputs from a shared set of
source clocks: one auxiliary PLL output and six frequency-generator outputs.
Each output has a 5-bit field in a single 32-bit configuration word. The field
selects a source and a small post-divide. A source code of zero switches the
output off. The source clocks are sampled as levels in the block's system clock
domain. Each output is a registered waveform that follows its selected source,
one system clock later.

A two-entry variant parameter picks the post-divide table. The default table
has no divide-by-3. The alternate table replaces one of its divide-by-1 codes
with divide-by-3. A second parameter marks which output slots exist in a given
configuration; an absent slot is tied low.

Reconfiguration never produces a runt pulse. A new field value is taken up only
at the end of the running output period. The output then holds low until the
next rising edge of the newly chosen source. At that edge the post-divider
restarts from count zero. Each output runs a three-state machine:

- `CH_OFF`: the output is held low.
- `CH_SYNC`: the new setting is loaded and the channel waits for a source rising edge.
- `CH_RUN`: the channel divides the selected source.

Its transitions are:

- `OFF->SYNC`: the field's source code becomes nonzero.
- `SYNC->RUN`: a rising edge arrives on the selected source with no further field change.
- `SYNC->SYNC`: a reload happens because the field changed again while waiting.
- `SYNC->OFF`: the field's source code becomes zero.
- `RUN->SYNC`: the field changed to a nonzero source and the period boundary is reached.
- `RUN->OFF`: the field's source code became zero and the period boundary is reached.

Top module: `intclk_select`

## Requirements
- R1: Output i (0 to 5) is configured by bits [5i+4:5i] of the configuration word. Within a field, bits 4:2 are the source code and bits 1:0 are the post-divide code.
- R2: Source code 1 selects the auxiliary PLL input. Source codes 2 to 7 select generator inputs 0 to 5 respectively.
- R3: With ALT_DIV3=0, post-divide codes 0, 1, 2 and 3 divide by 1, 4, 1 and 2.
- R4: With ALT_DIV3=1, post-divide code 2 divides by 3. Codes 0, 1 and 3 keep their ratios of 1, 4 and 2.
- R5: Divide-by-2 and divide-by-4 give a 50% duty cycle in units of source periods. Divide-by-3 is high for one source period and low for two. Divide-by-1 reproduces the source levels. Every output lags its source by one system clock.
- R6: A field with source code 0 forces its output low from the end of the current output period onwards.
- R7: A field change takes effect only at an output period boundary. No high or low pulse shorter than a full phase of the involved clocks appears around the change.
- R8: After an enable or a source or divide change, the output stays low until the first rising edge of the new source. The divider then restarts from zero, so the first high phase has full length.
- R9: Reset clears the configuration word. When rd_en_i is high, rd_data_o shows the word on the next cycle with bits 31:30 reading zero. Writes ignore bits 31:30.
- R10: An output whose SLOT_USED bit is 0 stays low whatever its field holds. Its field is still stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples source levels and the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_clk_i | input | 1 | Auxiliary PLL clock level (source code 1) |
| gen_clk_i | input | 6 | Frequency generator clock levels (source codes 2 to 7) |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Configuration word to write |
| rd_en_i | input | 1 | Read strobe; data is returned on the next cycle |
| rd_data_o | output | 32 | Registered read data |
| int_clk_o | output | 6 | Internal clock outputs, one per slot |

## Verification
The assertions inside each channel check, on every cycle, the rules that hold regardless of the source clocks. The output is low while a channel is off or waiting for a source edge. The active setting never changes while a channel keeps running. Every start of a run begins at count zero with the output high.

The ratios, duty cycles and source routing of every field position show up only as pulse lengths over many source periods, so the bench scenarios measure those directly. The bench scenarios also cover the absence of short pulses across a live switch, the full-length first pulse after an enable, read-back with the top bits masked, and the tied-off slot.

// File: rtl/intclk_sel_pkg.sv
package intclk_sel_pkg;

    localparam int NUM_OUT = 6;
    localparam int NUM_GEN = 6;
    localparam int SRC_W   = 3;
    localparam int CODE_W  = 2;
    localparam int FIELD_W = SRC_W + CODE_W;
    localparam int REG_W   = 32;
    localparam int USED_W  = NUM_OUT * FIELD_W;
    localparam int CNT_W   = 2;
    localparam int DIV_W   = 3;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_SYNC = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_t;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [CODE_W-1:0] code;
    } field_t;

    // post-divide table; code 2 is the variant-dependent entry
    function automatic logic [DIV_W-1:0] post_div(input logic [CODE_W-1:0] code,
                                                  input bit alt);
        logic [DIV_W-1:0] n;
        case (code)
            2'd0:    n = 3'd1;
            2'd1:    n = 3'd4;
            2'd2:    n = alt ? 3'd3 : 3'd1;
            default: n = 3'd2;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/intclk_sel_regs.sv
module intclk_sel_regs
    import intclk_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              rd_en_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic [USED_W-1:0] fields_o
);

    localparam int PAD_W = REG_W - USED_W;

    logic [USED_W-1:0] cfg_q;
    logic [REG_W-1:0]  rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            rd_q  <= '0;
        end else begin
            if (wr_en_i) begin
                cfg_q <= wr_data_i[USED_W-1:0];
            end
            if (rd_en_i) begin
                rd_q <= {{PAD_W{1'b0}}, cfg_q};
            end
        end
    end

    assign fields_o  = cfg_q;
    assign rd_data_o = rd_q;

    logic unused_hi;
    assign unused_hi = ^wr_data_i[REG_W-1:USED_W];

endmodule

// File: rtl/intclk_sel_srcmux.sv
module intclk_sel_srcmux
    import intclk_sel_pkg::*;
(
    input  logic [SRC_W-1:0]   sel_i,
    input  logic               aux_i,
    input  logic [NUM_GEN-1:0] gen_i,
    output logic               level_o
);

    // code 0: off, 1: auxiliary PLL, 2..7: generator 0..5
    always_comb begin
        level_o = 1'b0;
        if (sel_i == SRC_W'(1)) begin
            level_o = aux_i;
        end
        for (int k = 0; k < NUM_GEN; k++) begin
            if (sel_i == SRC_W'(k + 2)) begin
                level_o = gen_i[k];
            end
        end
    end

endmodule

// File: rtl/intclk_sel_chan.sv
module intclk_sel_chan
    import intclk_sel_pkg::*;
#(
    parameter bit ALT_DIV3 = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               aux_i,
    input  logic [NUM_GEN-1:0] gen_i,
    output logic               clk_o
);

    ch_state_t         st_q, st_nxt;
    field_t            want, act_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic              prev_q, out_q;
    logic              lvl, rise, pending, last, boundary;
    logic [DIV_W-1:0]  div_n, hi_len;

    assign want = field_t'(field_i);

    intclk_sel_srcmux u_mux (
        .sel_i   (act_q.src),
        .aux_i   (aux_i),
        .gen_i   (gen_i),
        .level_o (lvl)
    );

    // divider bookkeeping for the active setting
    always_comb begin
        div_n    = post_div(act_q.code, ALT_DIV3);
        hi_len   = (div_n == 3'd3) ? 3'd1 : (div_n >> 1);
        rise     = lvl & ~prev_q;
        pending  = (want != act_q);
        last     = ({1'b0, cnt_q} == (div_n - 3'd1));
        cnt_nxt  = last ? '0 : cnt_q + 1'b1;
        // divide-by-1 ends its period whenever the source is low
        boundary = (div_n == 3'd1) ? ~lvl : (rise & last);
    end

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            CH_OFF: begin
                if (want.src != '0) st_nxt = CH_SYNC;
            end
            CH_SYNC: begin
                if (want.src == '0)        st_nxt = CH_OFF;
                else if (rise && !pending) st_nxt = CH_RUN;
            end
            CH_RUN: begin
                if (pending && boundary) begin
                    st_nxt = (want.src == '0) ? CH_OFF : CH_SYNC;
                end
            end
            default: st_nxt = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_nxt;
    end

    // datapath and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            cnt_q  <= '0;
            prev_q <= 1'b1;
            out_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            unique case (st_q)
                CH_OFF: begin
                    out_q <= 1'b0;
                    cnt_q <= '0;
                    if (want.src != '0) begin
                        act_q  <= want;
                        prev_q <= 1'b1;
                    end
                end
                CH_SYNC: begin
                    if (pending) begin
                        act_q  <= want;
                        prev_q <= 1'b1;
                        out_q  <= 1'b0;
                    end else if (rise) begin
                        cnt_q <= '0;
                        out_q <= 1'b1;
                    end else begin
                        out_q <= 1'b0;
                    end
                end
                CH_RUN: begin
                    if (pending && boundary) begin
                        act_q  <= want;
                        prev_q <= 1'b1;
                        out_q  <= 1'b0;
                        cnt_q  <= '0;
                    end else if (div_n == 3'd1) begin
                        out_q <= lvl;
                    end else if (rise) begin
                        cnt_q <= cnt_nxt;
                        out_q <= ({1'b0, cnt_nxt} < hi_len);
                    end
                end
                default: out_q <= 1'b0;
            endcase
        end
    end

    assign clk_o = out_q;

    // R6: an off channel drives low
    a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_OFF) |-> !clk_o)
        else $error("a_r6_off_low");

    // R8: waiting for the new source keeps the output low
    a_r8_sync_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_SYNC) |-> !clk_o)
        else $error("a_r8_sync_low");

    // R7: the active setting is frozen while a channel keeps running
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN && $past(st_q) == CH_RUN) |-> $stable(act_q))
        else $error("a_r7_cfg_hold");

    // R8: every run starts from count zero with a high phase
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == CH_SYNC && st_q == CH_RUN) |-> (cnt_q == '0 && clk_o))
        else $error("a_r8_restart");

endmodule

// File: rtl/intclk_select.sv
module intclk_select
    import intclk_sel_pkg::*;
#(
    parameter bit               ALT_DIV3  = 1'b0,
    parameter logic [NUM_OUT-1:0] SLOT_USED = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               aux_clk_i,
    input  logic [NUM_GEN-1:0] gen_clk_i,
    input  logic               wr_en_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic               rd_en_i,
    output logic [REG_W-1:0]   rd_data_o,
    output logic [NUM_OUT-1:0] int_clk_o
);

    logic [USED_W-1:0] fields;

    intclk_sel_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .fields_o  (fields)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_slot
        if (SLOT_USED[i]) begin : g_on
            intclk_sel_chan #(.ALT_DIV3(ALT_DIV3)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .field_i (fields[i*FIELD_W +: FIELD_W]),
                .aux_i   (aux_clk_i),
                .gen_i   (gen_clk_i),
                .clk_o   (int_clk_o[i])
            );
        end else begin : g_off
            assign int_clk_o[i] = 1'b0;
        end
    end

endmodule

// File: tb/tb_intclk_select.sv
`timescale 1ns/1ps
module tb_intclk_select;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aux = 1'b0;
    logic [5:0]  gen = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_d, rd_a;
    logic [5:0]  out_d, out_a;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    intclk_select dut (
        .clk(clk), .rst_n(rst_n), .aux_clk_i(aux), .gen_clk_i(gen),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
        .rd_data_o(rd_d), .int_clk_o(out_d));

    intclk_select #(.ALT_DIV3(1'b1), .SLOT_USED(6'b011111)) dut_alt (
        .clk(clk), .rst_n(rst_n), .aux_clk_i(aux), .gen_clk_i(gen),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
        .rd_data_o(rd_a), .int_clk_o(out_a));

    // source levels: aux half-period 3, generator k half-period k+2
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            aux = ((cyc / 3) % 2) == 1;
            for (int k = 0; k < 6; k++) gen[k] = ((cyc / (k + 2)) % 2) == 1;
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic outv(input bit alt, input int ch);
        return alt ? out_a[ch] : out_d[ch];
    endfunction

    function automatic logic [31:0] put(input logic [31:0] w, input int ch,
                                        input logic [2:0] src, input logic [1:0] code);
        logic [31:0] r = w;
        r[5*ch +: 5] = {src, code};   // R1 field layout
        return r;
    endfunction

    task automatic wr(input logic [31:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [31:0] d, output logic [31:0] a);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_d; a = rd_a;
    endtask

    task automatic measure(input bit alt, input int ch, output int hi, output int lo);
        while (outv(alt, ch)) @(negedge clk);
        while (!outv(alt, ch)) @(negedge clk);
        hi = 0;
        while (outv(alt, ch)) begin hi++; @(negedge clk); end
        lo = 0;
        while (!outv(alt, ch)) begin lo++; @(negedge clk); end
    endtask

    logic [31:0] tbl;

    task automatic t_reset();
        logic [31:0] d, a;
        rd(d, a);
        chk("R9 reset word", int'(d), 0);
        chk("R6 outputs low after reset", int'(out_d), 0);
    endtask

    task automatic t_regs();
        logic [31:0] d, a;
        wr(32'hC000_0000);
        rd(d, a);
        chk("R9 top bits ignored", int'(d), 0);
        wr(32'hFFFF_FFFF);
        rd(d, a);
        chk("R9 all fields read back", int'(d), 32'h3FFF_FFFF);
        chk("R10 unused slot field kept", int'(a), 32'h3FFF_FFFF);
        wr(32'h0);
        repeat (120) @(negedge clk);
    endtask

    task automatic t_table();
        int hi, lo;
        logic [31:0] d, a;
        tbl = '0;
        tbl = put(tbl, 0, 3'd1, 2'd3);  // aux /2
        tbl = put(tbl, 1, 3'd2, 2'd1);  // gen0 /4
        tbl = put(tbl, 2, 3'd3, 2'd0);  // gen1 /1
        tbl = put(tbl, 3, 3'd5, 2'd2);  // gen3 code 2
        tbl = put(tbl, 4, 3'd7, 2'd3);  // gen5 /2
        tbl = put(tbl, 5, 3'd4, 2'd1);  // gen2 /4
        wr(tbl);
        rd(d, a);
        chk("R1 read back table word", int'(d), int'(tbl));
        repeat (80) @(negedge clk);
        measure(0, 0, hi, lo); chk("R2 R5 ch0 aux div2 high", hi, 6);  chk("R5 ch0 low", lo, 6);
        measure(0, 1, hi, lo); chk("R3 ch1 gen0 div4 high", hi, 8);    chk("R5 ch1 low", lo, 8);
        measure(0, 2, hi, lo); chk("R3 ch2 gen1 div1 high", hi, 3);    chk("R5 ch2 low", lo, 3);
        measure(0, 3, hi, lo); chk("R3 ch3 code2 div1 high", hi, 5);   chk("R3 ch3 low", lo, 5);
        measure(0, 4, hi, lo); chk("R2 ch4 gen5 div2 high", hi, 14);   chk("R5 ch4 low", lo, 14);
        measure(0, 5, hi, lo); chk("R1 ch5 gen2 div4 high", hi, 16);   chk("R5 ch5 low", lo, 16);
        measure(1, 3, hi, lo); chk("R4 alt code2 div3 high", hi, 10);  chk("R4 alt div3 low", lo, 20);
        measure(1, 1, hi, lo); chk("R4 alt code1 div4 high", hi, 8);   chk("R4 alt div4 low", lo, 8);
        measure(1, 0, hi, lo); chk("R4 alt code3 div2 high", hi, 6);
    endtask

    task automatic t_slot();
        int edges = 0;
        int highs = 0;
        logic p = out_a[4];
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (out_a[5]) highs++;
            if (out_a[4] != p) edges++;
            p = out_a[4];
        end
        chk("R10 unused slot stays low", highs, 0);
        chk("R10 neighbour slot toggles", int'(edges > 0), 1);
    endtask

    task automatic t_disable();
        int highs = 0;
        tbl = put(tbl, 2, 3'd0, 2'd0);
        wr(tbl);
        repeat (40) @(negedge clk);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (out_d[2]) highs++;
        end
        chk("R6 disabled output held low", highs, 0);
    endtask

    task automatic t_restart();
        int hi, lo, wait_lo, highs_before;
        tbl = put(tbl, 2, 3'd5, 2'd1);  // gen3 (half 5) /4
        wr(tbl);
        wait_lo = 0;
        highs_before = 0;
        while (!out_d[2] && wait_lo < 100) begin wait_lo++; @(negedge clk); end
        chk("R8 low before first edge", int'(wait_lo >= 1), 1);
        hi = 0;
        while (out_d[2]) begin hi++; @(negedge clk); end
        lo = 0;
        while (!out_d[2]) begin lo++; @(negedge clk); end
        chk("R8 first high full length", hi, 20);
        chk("R8 first low full length", lo, 20);
        if (highs_before != 0) chk("R8 spurious high", highs_before, 0);
    endtask

    task automatic t_switch();
        int run = 0;
        int min_hi = 1000;
        int min_lo = 1000;
        bit started = 0;
        int hi, lo;
        logic p;
        tbl = put(tbl, 0, 3'd6, 2'd1);  // gen4 (half 6) /4
        wr(tbl);
        p = out_d[0];
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (out_d[0] != p) begin
                if (started) begin
                    if (p) begin if (run < min_hi) min_hi = run; end
                    else   begin if (run < min_lo) min_lo = run; end
                end
                started = 1;
                run = 1;
            end else begin
                run++;
            end
            p = out_d[0];
        end
        chk("R7 no short high across switch", int'(min_hi >= 6), 1);
        chk("R7 no short low across switch", int'(min_lo >= 6), 1);
        measure(0, 0, hi, lo);
        chk("R7 new setting high", hi, 24);
        chk("R7 new setting low", lo, 24);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_table();
        t_slot();
        t_disable();
        t_restart();
        t_switch();
        summary();
        $finish;
    end

endmodule